// File: doc/BRIEF.md
# UART Modem Control Register

This block holds the eight-bit modem control setting of one serial channel. Software reaches it over a small register bus that has a write enable, a read enable, an address and a data path. The stored value is also exported as a vector for the rest of the channel.

From that value the block drives the active-low DTR and RTS pins. It picks which pin pair carries automatic hardware flow control. It raises the enables for internal loopback, Xon-any and infrared mode.

It also builds a clock-enable strobe for the baud generator. Depending on one bit, the strobe passes every clock or one clock in four. In infrared mode the transmit line idles low instead of high. The reset value of the infrared bit comes from a strap input sampled when reset is released.

Top module: `uart_mcr_ctrl`

## Requirements
- R1: While reset is held, and after reset is released, bits 0, 1, 2, 3, 4, 5 and 7 of the register read 0. After reset, `dtr_n_o` and `rts_n_o` are both 1.
- R2: A write with `bus_addr_i` equal to parameter REG_ADDR (default 0) stores the write data, but bit 3 is reserved: it always reads 0 and ignores writes. Writes to other addresses change nothing. A read at REG_ADDR returns the register on `bus_rdata_o` in the same cycle; a read elsewhere returns 0.
- R3: When a pin is not under automatic control, `dtr_n_o` is the inverse of bit 0 and `rts_n_o` is the inverse of bit 1.
- R4: With `auto_flow_en_i` high and bit 2 equal to 0, `rts_n_o` is the inverse of `rx_ready_i` and `tx_allow_o` is the inverse of `cts_n_i`. With bit 2 equal to 1, `dtr_n_o` is the inverse of `rx_ready_i` and `tx_allow_o` is the inverse of `dsr_n_i`. In either case the pin that is not selected stays under register control. With `auto_flow_en_i` low, `tx_allow_o` is 1.
- R5: `loopback_en_o` follows bit 4 and `xon_any_en_o` follows bit 5.
- R6: `xon_resume_o` pulses for one cycle, in the same cycle as `rx_char_stb_i`, for the first character strobe seen while bit 5 is set and `tx_paused_i` is high. Further strobes in the same pause give no pulse. A new pulse needs `tx_paused_i` to go low and then high again.
- R7: Bit 6 loads the level of `strap_ir_i` in the first clock after reset is released. Software can overwrite it afterwards.
- R8: `ir_en_o` follows bit 6. `tx_idle_lvl_o` is 0 when bit 6 is set and 1 otherwise.
- R9: With bit 7 clear, `baud_tick_o` is high in every cycle.
- R10: With bit 7 set, `baud_tick_o` is high in one cycle of every four. Any change of bit 7 clears the divider count, so the first strobe comes in the fourth cycle after the write edge that set bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_ir_i | input | 1 | Strap level that sets the infrared default |
| bus_we_i | input | 1 | Register write enable |
| bus_re_i | input | 1 | Register read enable |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data |
| mcr_q_o | output | 8 | Current register contents |
| auto_flow_en_i | input | 1 | Automatic hardware flow control on |
| rx_ready_i | input | 1 | Receiver can accept data |
| cts_n_i | input | 1 | Clear-to-send pin, active low |
| dsr_n_i | input | 1 | Data-set-ready pin, active low |
| dtr_n_o | output | 1 | DTR pin, active low |
| rts_n_o | output | 1 | RTS pin, active low |
| tx_allow_o | output | 1 | Transmitter may send |
| loopback_en_o | output | 1 | Internal loopback enable |
| ir_en_o | output | 1 | Infrared mode enable |
| tx_idle_lvl_o | output | 1 | Idle level of the transmit line |
| tx_paused_i | input | 1 | Transmission paused by software flow control |
| rx_char_stb_i | input | 1 | A character was received |
| xon_any_en_o | output | 1 | Xon-any enable |
| xon_resume_o | output | 1 | Resume-transmission pulse |
| baud_tick_o | output | 1 | Clock-enable strobe to the baud generator |

## Verification
Several properties are checked on every cycle:
- The reserved bit always reads zero.
- Each pin that is under register control keeps the inverse polarity of its bit.
- The automatically routed receive-side pin follows the ready input.
- A resume pulse appears only together with a strobe, while the transmitter is paused and the feature is on, and never lasts two cycles.
- The strobe is present on every cycle in divide-by-one mode and is followed by a gap in divide-by-four mode.

Some behaviour can only be shown by the bench's scenarios:
- The strap capture at reset release, and a later software override of that bit.
- The exact phase of the first strobe after the divide mode changes.
- That a second character in the same pause gives no pulse.
- That writes to a foreign address are ignored.

// File: rtl/uart_mcr_pkg.sv
package uart_mcr_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned B_DTR   = 0;
  localparam int unsigned B_RTS   = 1;
  localparam int unsigned B_FSEL  = 2;
  localparam int unsigned B_RSVD  = 3;
  localparam int unsigned B_LOOP  = 4;
  localparam int unsigned B_XANY  = 5;
  localparam int unsigned B_IR    = 6;
  localparam int unsigned B_PRE   = 7;
  localparam logic [REG_W-1:0] RSVD_MASK = REG_W'(1) << B_RSVD;
endpackage

// File: rtl/uart_mcr_rst_sync.sv
module uart_mcr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/uart_mcr_regs.sv
module uart_mcr_regs
  import uart_mcr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_s_n,
  input  logic              strap_ir_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic [REG_W-1:0]  mcr_q_o
);
  localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(REG_ADDR);

  logic             hit;
  logic             wr_en;
  logic             strap_done_q;
  logic             strap_done_d;
  logic [REG_W-1:0] mcr_d;

  assign hit   = (bus_addr_i == SEL_ADDR);
  assign wr_en = bus_we_i && hit;

  always_comb begin
    strap_done_d = 1'b1;
    mcr_d        = mcr_q_o;
    if (!strap_done_q) mcr_d[B_IR] = strap_ir_i;
    if (wr_en)         mcr_d       = bus_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) strap_done_q <= 1'b0;
    else          strap_done_q <= strap_done_d;
  end

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (RSVD_MASK[b]) begin : g_rsvd
      assign mcr_q_o[b] = 1'b0;
    end else begin : g_store
      logic bit_q;
      always_ff @(posedge clk or negedge rst_s_n) begin
        if (!rst_s_n) bit_q <= 1'b0;
        else          bit_q <= mcr_d[b];
      end
      assign mcr_q_o[b] = bit_q;
    end
  end

  assign bus_rdata_o = (bus_re_i && hit) ? mcr_q_o : '0;
endmodule

// File: rtl/uart_mcr_flow.sv
module uart_mcr_flow (
  input  logic dtr_bit_i,
  input  logic rts_bit_i,
  input  logic fsel_i,
  input  logic auto_flow_en_i,
  input  logic rx_ready_i,
  input  logic cts_n_i,
  input  logic dsr_n_i,
  output logic dtr_n_o,
  output logic rts_n_o,
  output logic tx_allow_o
);
  logic auto_rts;
  logic auto_dtr;

  assign auto_rts = auto_flow_en_i && !fsel_i;
  assign auto_dtr = auto_flow_en_i &&  fsel_i;

  always_comb begin
    rts_n_o    = auto_rts ? !rx_ready_i : !rts_bit_i;
    dtr_n_o    = auto_dtr ? !rx_ready_i : !dtr_bit_i;
    tx_allow_o = 1'b1;
    if (auto_rts) tx_allow_o = !cts_n_i;
    if (auto_dtr) tx_allow_o = !dsr_n_i;
  end
endmodule

// File: rtl/uart_mcr_xon.sv
module uart_mcr_xon (
  input  logic clk,
  input  logic rst_s_n,
  input  logic xany_en_i,
  input  logic tx_paused_i,
  input  logic rx_char_stb_i,
  output logic resume_o
);
  logic armed_q;
  logic armed_d;

  assign resume_o = armed_q && xany_en_i && tx_paused_i && rx_char_stb_i;

  always_comb begin
    armed_d = armed_q;
    if (!tx_paused_i) armed_d = 1'b1;
    else if (resume_o) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) armed_q <= 1'b1;
    else          armed_q <= armed_d;
  end
endmodule

// File: rtl/uart_mcr_presc.sv
module uart_mcr_presc #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_s_n,
  input  logic sel_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic          sel_q;
  logic          changed;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign changed = (sel_i != sel_q);

  always_comb begin
    if (changed || !sel_i || cnt_q == LAST) cnt_d = '0;
    else                                    cnt_d = cnt_q + CW'(1);
  end

  assign tick_o = !sel_i || (!changed && cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      sel_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      sel_q <= sel_i;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/uart_mcr_ctrl.sv
module uart_mcr_ctrl
  import uart_mcr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned REG_ADDR = 0,
  parameter int unsigned PRE_DIV  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_ir_i,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic [7:0]        mcr_q_o,
  input  logic              auto_flow_en_i,
  input  logic              rx_ready_i,
  input  logic              cts_n_i,
  input  logic              dsr_n_i,
  output logic              dtr_n_o,
  output logic              rts_n_o,
  output logic              tx_allow_o,
  output logic              loopback_en_o,
  output logic              ir_en_o,
  output logic              tx_idle_lvl_o,
  input  logic              tx_paused_i,
  input  logic              rx_char_stb_i,
  output logic              xon_any_en_o,
  output logic              xon_resume_o,
  output logic              baud_tick_o
);
  logic rst_s_n;

  uart_mcr_rst_sync #(.STAGES(2)) rsync_i (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  uart_mcr_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) regs_i (
    .clk(clk), .rst_s_n(rst_s_n), .strap_ir_i(strap_ir_i),
    .bus_we_i(bus_we_i), .bus_re_i(bus_re_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .mcr_q_o(mcr_q_o)
  );

  uart_mcr_flow flow_i (
    .dtr_bit_i(mcr_q_o[B_DTR]), .rts_bit_i(mcr_q_o[B_RTS]),
    .fsel_i(mcr_q_o[B_FSEL]), .auto_flow_en_i(auto_flow_en_i),
    .rx_ready_i(rx_ready_i), .cts_n_i(cts_n_i), .dsr_n_i(dsr_n_i),
    .dtr_n_o(dtr_n_o), .rts_n_o(rts_n_o), .tx_allow_o(tx_allow_o)
  );

  uart_mcr_xon xon_i (
    .clk(clk), .rst_s_n(rst_s_n), .xany_en_i(mcr_q_o[B_XANY]),
    .tx_paused_i(tx_paused_i), .rx_char_stb_i(rx_char_stb_i),
    .resume_o(xon_resume_o)
  );

  uart_mcr_presc #(.DIV(PRE_DIV)) presc_i (
    .clk(clk), .rst_s_n(rst_s_n), .sel_i(mcr_q_o[B_PRE]), .tick_o(baud_tick_o)
  );

  assign loopback_en_o = mcr_q_o[B_LOOP];
  assign xon_any_en_o  = mcr_q_o[B_XANY];
  assign ir_en_o       = mcr_q_o[B_IR];
  assign tx_idle_lvl_o = !mcr_q_o[B_IR];
endmodule

// File: rtl/uart_mcr_ctrl_chk.sv
module uart_mcr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_rdata_o,
  input logic [7:0] mcr_q_o,
  input logic       auto_flow_en_i,
  input logic       rx_ready_i,
  input logic       dtr_n_o,
  input logic       rts_n_o,
  input logic       tx_idle_lvl_o,
  input logic       tx_paused_i,
  input logic       rx_char_stb_i,
  input logic       xon_resume_o,
  input logic       baud_tick_o
);
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mcr_q_o[3] && !bus_rdata_o[3]);

  a_r3_dtr_manual: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_flow_en_i || !mcr_q_o[2]) |-> (dtr_n_o == !mcr_q_o[0]));

  a_r3_rts_manual: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_flow_en_i || mcr_q_o[2]) |-> (rts_n_o == !mcr_q_o[1]));

  a_r4_auto_rx_pin: assert property (@(posedge clk) disable iff (!rst_n)
    auto_flow_en_i |-> ((mcr_q_o[2] ? dtr_n_o : rts_n_o) == !rx_ready_i));

  a_r6_resume_cond: assert property (@(posedge clk) disable iff (!rst_n)
    xon_resume_o |-> (rx_char_stb_i && tx_paused_i && mcr_q_o[5]));

  a_r6_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
    xon_resume_o |=> !xon_resume_o);

  a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle_lvl_o == !mcr_q_o[6]);

  a_r9_div1_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!mcr_q_o[7] && $past(!mcr_q_o[7])) |-> baud_tick_o);

  a_r10_div4_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick_o && mcr_q_o[7] && $past(mcr_q_o[7])) |=> !baud_tick_o);
endmodule

bind uart_mcr_ctrl uart_mcr_ctrl_chk chk_i (.*);

// File: tb/uart_mcr_ctrl_tb_top.sv
module uart_mcr_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap_ir_i = 1'b1;
  logic       bus_we_i = 1'b0;
  logic       bus_re_i = 1'b0;
  logic [2:0] bus_addr_i = '0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic [7:0] mcr_q_o;
  logic       auto_flow_en_i = 1'b0;
  logic       rx_ready_i = 1'b0;
  logic       cts_n_i = 1'b1;
  logic       dsr_n_i = 1'b1;
  logic       dtr_n_o, rts_n_o, tx_allow_o, loopback_en_o, ir_en_o, tx_idle_lvl_o;
  logic       tx_paused_i = 1'b0;
  logic       rx_char_stb_i = 1'b0;
  logic       xon_any_en_o, xon_resume_o, baud_tick_o;

  int total = 0;
  int bad   = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_mcr_ctrl dut_i (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops the expected read value for every read cycle.
  always @(negedge clk) begin
    if (bus_re_i) begin
      if (exp_q.size() == 0) check("R2 unexpected read", bus_rdata_o, 8'h00);
      else check(tag_q.pop_front(), bus_rdata_o, exp_q.pop_front());
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step();
    bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    step();
    bus_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string req);
    step();
    exp_q.push_back(e); tag_q.push_back(req);
    bus_re_i = 1'b1; bus_addr_i = a;
    step();
    bus_re_i = 1'b0;
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0; strap_ir_i = strap;
    repeat (3) step();
    check("R1 reg in reset", mcr_q_o, 8'h00);
    rst_n = 1'b1;
    repeat (4) step();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    @(negedge clk);
    check("R1/R7 reset value with strap high", mcr_q_o, 8'h40);
    check("R1 pins high", {6'd0, dtr_n_o, rts_n_o}, 8'h03);
    check("R8 ir mode idle low", {6'd0, ir_en_o, tx_idle_lvl_o}, 8'h02);
    check("R9 div1 tick", {7'd0, baud_tick_o}, 8'h01);
    rd(3'd0, 8'h40, "R2 read after reset");

    wr(3'd0, 8'h00);
    rd(3'd0, 8'h00, "R7 software clears ir bit");
    @(negedge clk);
    check("R8 normal idle high", {6'd0, ir_en_o, tx_idle_lvl_o}, 8'h01);

    wr(3'd0, 8'h3F);
    rd(3'd0, 8'h37, "R2 reserved bit reads 0");
    rd(3'd1, 8'h00, "R2 foreign address reads 0");
    wr(3'd2, 8'hFF);
    rd(3'd0, 8'h37, "R2 foreign write ignored");
    @(negedge clk);
    check("R3 pins low", {6'd0, dtr_n_o, rts_n_o}, 8'h00);
    check("R5 loop/xany", {6'd0, loopback_en_o, xon_any_en_o}, 8'h03);
    wr(3'd0, 8'h02);
    @(negedge clk);
    check("R3 dtr high rts low", {6'd0, dtr_n_o, rts_n_o}, 8'h02);
    check("R5 enables off", {6'd0, loopback_en_o, xon_any_en_o}, 8'h00);
    check("R4 tx allowed without auto", {7'd0, tx_allow_o}, 8'h01);

    // auto flow, RTS/CTS pair; bit0 set so DTR low by register
    wr(3'd0, 8'h01);
    auto_flow_en_i = 1'b1; rx_ready_i = 1'b1; cts_n_i = 1'b1; dsr_n_i = 1'b0;
    @(negedge clk);
    check("R4 rts auto, dtr reg", {5'd0, dtr_n_o, rts_n_o, tx_allow_o}, 8'h00);
    step(); rx_ready_i = 1'b0; cts_n_i = 1'b0;
    @(negedge clk);
    check("R4 rts auto deassert", {5'd0, dtr_n_o, rts_n_o, tx_allow_o}, 8'h03);
    // DTR/DSR pair; bit1 set so RTS low by register
    wr(3'd0, 8'h06);
    rx_ready_i = 1'b1; cts_n_i = 1'b1; dsr_n_i = 1'b0;
    @(negedge clk);
    check("R4 dtr auto, rts reg", {5'd0, dtr_n_o, rts_n_o, tx_allow_o}, 8'h01);
    step(); rx_ready_i = 1'b0; dsr_n_i = 1'b1;
    @(negedge clk);
    check("R4 dtr auto deassert", {5'd0, dtr_n_o, rts_n_o, tx_allow_o}, 8'h04);
    auto_flow_en_i = 1'b0;

    // Xon-any
    wr(3'd0, 8'h20);
    tx_paused_i = 1'b1; rx_char_stb_i = 1'b1;
    @(negedge clk);
    check("R6 first char resumes", {7'd0, xon_resume_o}, 8'h01);
    step();
    @(negedge clk);
    check("R6 second char no pulse", {7'd0, xon_resume_o}, 8'h00);
    step(); rx_char_stb_i = 1'b0; tx_paused_i = 1'b0;
    step(); tx_paused_i = 1'b1; rx_char_stb_i = 1'b1;
    @(negedge clk);
    check("R6 rearmed after pause cycle", {7'd0, xon_resume_o}, 8'h01);
    step(); rx_char_stb_i = 1'b0; tx_paused_i = 1'b0;
    wr(3'd0, 8'h00);
    tx_paused_i = 1'b1; rx_char_stb_i = 1'b1;
    @(negedge clk);
    check("R6 disabled no pulse", {7'd0, xon_resume_o}, 8'h00);
    step(); rx_char_stb_i = 1'b0; tx_paused_i = 1'b0;

    // prescaler: ticks at k=4,8,12,16 after the write edge
    wr(3'd0, 8'h80);
    for (int k = 0; k < 17; k++) begin
      @(negedge clk);
      check($sformatf("R10 div4 cycle %0d", k), {7'd0, baud_tick_o},
            {7'd0, (k >= 4 && (k % 4) == 0)});
    end
    wr(3'd0, 8'h00);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R9 div1 after return", {7'd0, baud_tick_o}, 8'h01);
    end

    // reset with strap low
    do_reset(1'b0);
    @(negedge clk);
    check("R7 strap low reset value", mcr_q_o, 8'h00);
    check("R1 pins after second reset", {6'd0, dtr_n_o, rts_n_o}, 8'h03);

    repeat (2) step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule